// File: doc/BRIEF.md
# Next Program-Counter Address Generator

This block works out where a simple 32-bit load/store core fetches next. Addresses are held as 30-bit word addresses, since the two low byte-address bits are always zero. Each cycle the block looks at the current word address and the fields the decoder supplies: a 16-bit branch offset, a 26-bit jump field, two register operands and two small select codes. From these it produces the following word address and a link value that a call instruction can write to the register file.

A single adder, with its carry-in tied to one, does both sequential stepping and branch targets. Its second operand is zero, or the sign-extended offset when a branch condition holds. A built-in comparator evaluates the condition: equal, not equal, or negative. A four-way selector then picks the final address. A thin registered shell holds the current address, so the block can be driven cycle by cycle. It has an enable that advances the address and an asynchronous active-low reset that is released through a synchronizer.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and until two clock edges after `rst_n` rises, `pc_word` equals the parameter `RESET_WORD` (default 30'h0010_0000) and does not advance.
- R2: `link_pc` equals `pc_word + 1` modulo 2^30 whenever `br_taken` is 0. When a branch is taken it carries the branch target instead.
- R3: With `pc_src` = 2'b00 and no branch taken, `next_pc` is `pc_word + 1` modulo 2^30, so 30'h3FFF_FFFF wraps to 0.
- R4: With `pc_src` = 2'b00 and a branch taken, `next_pc` is `pc_word + 1 + sext(br_imm)` modulo 2^30. `br_imm` is sign-extended from bit 15.
- R5: `br_taken` depends on `br_kind`. Code 2'b00 never takes a branch. Code 2'b01 takes it when `rs_val == rt_val`. Code 2'b10 takes it when they differ. Code 2'b11 takes it when `rs_val[31]` is 1.
- R6: For any `pc_src` other than 2'b00, `next_pc` depends only on that selector's source. A branch condition that holds has no effect on it.
- R7: With `pc_src` = 2'b01, `next_pc` is the top 4 bits of `pc_word` followed by `jump_tgt[25:0]`.
- R8: With `pc_src` = 2'b10, `next_pc` is `rs_val[31:2]`.
- R9: With `pc_src` = 2'b11, `next_pc` is the parameter `SYSCALL_WORD` (default 30'h0000_0040).
- R10: On a rising clock edge out of reset, `pc_word` takes `next_pc` if `step_en` is 1 and keeps its value if `step_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Advance the held word address this edge |
| br_imm | input | 16 | Signed branch offset in words |
| jump_tgt | input | 26 | Jump field, low bits of an absolute word address |
| rs_val | input | 32 | First register operand (branch compare, register jump) |
| rt_val | input | 32 | Second register operand (branch compare) |
| br_kind | input | 2 | Branch condition: 00 none, 01 equal, 10 not equal, 11 negative |
| pc_src | input | 2 | Address source: 00 step/branch, 01 jump field, 10 register, 11 system-call entry |
| pc_word | output | 30 | Current word address |
| next_pc | output | 30 | Word address selected for the next fetch |
| link_pc | output | 30 | Shared adder result, the return address when no branch is taken |
| br_taken | output | 1 | Branch condition holds |

## Verification
Every cycle, the embedded properties check how the register responds to `step_en`. They also check that the sequential path, the link value, the jump splice and the system-call entry match the current address, and that the "none" branch code never reports a taken branch. Several behaviours can be shown only by the bench's scenarios, because they need the operands and the expected arithmetic. These include whether each comparison is correct, the value of a sign-extended target that wraps around, the register-jump source, the reset value and synchronizer delay, and the fact that a true branch condition is ignored under non-sequential sources.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    BRK_NONE = 2'b00,
    BRK_EQ   = 2'b01,
    BRK_NE   = 2'b10,
    BRK_LTZ  = 2'b11
  } brk_e;

  typedef enum logic [1:0] {
    SRC_STEP = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_TRAP = 2'b11
  } src_e;

endpackage

// File: rtl/npc_reset_sync.sv
module npc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/npc_branch_check.sv
module npc_branch_check
  import npc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        kind,
  output logic              taken
);

  brk_e kind_e;
  logic same;

  always_comb begin
    kind_e = brk_e'(kind);
    same   = (opa == opb);
    unique case (kind_e)
      BRK_EQ:  taken = same;
      BRK_NE:  taken = !same;
      BRK_LTZ: taken = opa[DATA_W-1];
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
  parameter int PC_W  = 30,
  parameter int IMM_W = 16
) (
  input  logic [PC_W-1:0]  base,
  input  logic [IMM_W-1:0] offset,
  input  logic             use_off,
  output logic [PC_W-1:0]  sum
);

  localparam int EXT_W = PC_W - IMM_W;

  logic [PC_W-1:0] addend;
  logic [PC_W-1:0] carry_in;

  always_comb begin
    if (use_off) addend = {{EXT_W{offset[IMM_W-1]}}, offset};
    else         addend = '0;
    carry_in = {{(PC_W-1){1'b0}}, 1'b1};
    sum      = base + addend + carry_in;
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int              PC_W         = 30,
  parameter int              JT_W         = 26,
  parameter logic [PC_W-1:0] SYSCALL_WORD = 30'h0000_0040
) (
  input  logic [PC_W-1:0]      seq_word,
  input  logic [PC_W-1:JT_W]   pc_top,
  input  logic [JT_W-1:0]      jump_tgt,
  input  logic [PC_W-1:0]      reg_word,
  input  logic [1:0]           src,
  output logic [PC_W-1:0]      chosen
);

  src_e src_e_v;

  always_comb begin
    src_e_v = src_e'(src);
    unique case (src_e_v)
      SRC_JUMP: chosen = {pc_top, jump_tgt};
      SRC_REG:  chosen = reg_word;
      SRC_TRAP: chosen = SYSCALL_WORD;
      default:  chosen = seq_word;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IMM_W        = 16,
  parameter int JT_W         = 26,
  parameter int RST_STAGES   = 2,
  parameter logic [DATA_W-3:0] SYSCALL_WORD = 30'h0000_0040,
  parameter logic [DATA_W-3:0] RESET_WORD   = 30'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [IMM_W-1:0]  br_imm,
  input  logic [JT_W-1:0]   jump_tgt,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [1:0]        br_kind,
  input  logic [1:0]        pc_src,
  output logic [DATA_W-3:0] pc_word,
  output logic [DATA_W-3:0] next_pc,
  output logic [DATA_W-3:0] link_pc,
  output logic              br_taken
);

  localparam int PC_W = DATA_W - 2;
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] seq_sum;
  logic [PC_W-1:0] sel_word;
  logic            taken;

  npc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_branch_check #(.DATA_W(DATA_W)) u_cond (
    .opa   (rs_val),
    .opb   (rt_val),
    .kind  (br_kind),
    .taken (taken)
  );

  npc_seq_adder #(.PC_W(PC_W), .IMM_W(IMM_W)) u_add (
    .base    (pc_q),
    .offset  (br_imm),
    .use_off (taken),
    .sum     (seq_sum)
  );

  npc_select #(.PC_W(PC_W), .JT_W(JT_W), .SYSCALL_WORD(SYSCALL_WORD)) u_sel (
    .seq_word (seq_sum),
    .pc_top   (pc_q[PC_W-1:JT_W]),
    .jump_tgt (jump_tgt),
    .reg_word (rs_val[DATA_W-1:2]),
    .src      (pc_src),
    .chosen   (sel_word)
  );

  always_comb begin
    if (step_en) pc_d = sel_word;
    else         pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= RESET_WORD;
    else             pc_q <= pc_d;
  end

  assign pc_word  = pc_q;
  assign next_pc  = sel_word;
  assign link_pc  = seq_sum;
  assign br_taken = taken;

  assert_pc_load_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en |=> (pc_word == $past(next_pc)));

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !step_en |=> $stable(pc_word));

  assert_step_path_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_src == 2'b00 && !br_taken) |-> (next_pc == pc_word + ONE));

  assert_link_value_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !br_taken |-> (link_pc == pc_word + ONE));

  assert_jump_splice_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_src == 2'b01) |-> (next_pc[PC_W-1:JT_W] == pc_word[PC_W-1:JT_W]
                           && next_pc[JT_W-1:0] == jump_tgt));

  assert_trap_entry_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_src == 2'b11) |-> (next_pc == SYSCALL_WORD));

  assert_no_cond_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_kind == 2'b00) |-> !br_taken);

endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

  localparam logic [29:0] SYS_W = 30'h0000_0040;
  localparam logic [29:0] RST_W = 30'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [15:0] br_imm;
  logic [25:0] jump_tgt;
  logic [31:0] rs_val, rt_val;
  logic [1:0]  br_kind, pc_src;
  logic [29:0] pc_word, next_pc, link_pc;
  logic        br_taken;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [29:0] mpc;

  always #4 clk = ~clk;

  npc_unit #(.SYSCALL_WORD(SYS_W), .RESET_WORD(RST_W)) u_npc_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .br_imm(br_imm),
    .jump_tgt(jump_tgt), .rs_val(rs_val), .rt_val(rt_val),
    .br_kind(br_kind), .pc_src(pc_src), .pc_word(pc_word),
    .next_pc(next_pc), .link_pc(link_pc), .br_taken(br_taken)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cond_of(logic [1:0] k, logic [31:0] a, logic [31:0] b);
    case (k)
      2'b01:   return a == b;
      2'b10:   return a != b;
      2'b11:   return a[31];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [29:0] sext(logic [15:0] v);
    return {{14{v[15]}}, v};
  endfunction

  task automatic step(logic [15:0] imm, logic [25:0] jt, logic [31:0] a,
                      logic [31:0] b, logic [1:0] k, logic [1:0] s, logic en);
    logic tk;
    logic [29:0] lk, nx;
    string nt;
    br_imm = imm; jump_tgt = jt; rs_val = a; rt_val = b;
    br_kind = k; pc_src = s; step_en = en;
    #1;
    tk = cond_of(k, a, b);
    lk = mpc + 30'd1 + (tk ? sext(imm) : 30'd0);
    case (s)
      2'b00: begin nx = lk;              nt = tk ? "R4 branch" : "R3 step"; end
      2'b01: begin nx = {mpc[29:26], jt}; nt = "R7 jump"; end
      2'b10: begin nx = a[31:2];         nt = "R8 regjump"; end
      default: begin nx = SYS_W;         nt = "R9 trap"; end
    endcase
    if (s != 2'b00 && tk) nt = {nt, " R6 cond ignored"};
    chk("R5 br_taken", {31'd0, br_taken}, {31'd0, tk});
    chk("R2 link_pc", {2'b0, link_pc}, {2'b0, lk});
    chk(nt, {2'b0, next_pc}, {2'b0, nx});
    @(negedge clk);
    if (en) mpc = nx;
    chk("R10 pc_word after edge", {2'b0, pc_word}, {2'b0, mpc});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r, a, b;
    r = $urandom(32'h5EED_1234);
    rst_n = 1'b0; step_en = 1'b1; br_imm = '0; jump_tgt = '0;
    rs_val = '0; rt_val = '0; br_kind = '0; pc_src = '0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", {2'b0, pc_word}, {2'b0, RST_W});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held during sync release", {2'b0, pc_word}, {2'b0, RST_W});
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pc after release", {2'b0, pc_word}, {2'b0, RST_W});
    mpc = RST_W;

    step(16'h0005, 26'h0, 32'h1, 32'h2, 2'b00, 2'b00, 1'b1);       // R3
    step(16'h0010, 26'h0, 32'hAB, 32'hAB, 2'b01, 2'b00, 1'b1);     // R4 beq taken
    step(16'h0010, 26'h0, 32'hAB, 32'hAC, 2'b01, 2'b00, 1'b1);     // R5 beq not taken
    step(16'hFFF0, 26'h0, 32'h1, 32'h2, 2'b10, 2'b00, 1'b1);       // R4 negative offset
    step(16'h0040, 26'h0, 32'h8000_0000, 32'h0, 2'b11, 2'b00, 1'b1); // R5 bltz taken
    step(16'h0040, 26'h0, 32'h7FFF_FFFF, 32'h0, 2'b11, 2'b00, 1'b1); // R5 bltz not taken
    step(16'h0000, 26'h0, 32'h5, 32'h5, 2'b10, 2'b00, 1'b1);       // R5 bne not taken
    step(16'h0000, 26'h0, 32'hFFFF_FFFC, 32'h0, 2'b00, 2'b10, 1'b1); // R8 to top
    step(16'h0000, 26'h0, 32'h0, 32'h1, 2'b00, 2'b00, 1'b1);       // R3 wrap to 0
    step(16'hFFFE, 26'h0, 32'h3, 32'h3, 2'b01, 2'b00, 1'b1);       // R4 wrap below 0
    step(16'h0000, 26'h3AB_CDEF, 32'h0, 32'h0, 2'b00, 2'b01, 1'b1); // R7
    step(16'h0100, 26'h0, 32'h9, 32'h9, 2'b01, 2'b11, 1'b1);       // R9 + R6
    step(16'h0100, 26'h155_5555, 32'h9, 32'h9, 2'b01, 2'b01, 1'b1); // R6 jump
    step(16'h0100, 26'h0, 32'h8000_0010, 32'h0, 2'b11, 2'b10, 1'b1); // R6 regjump
    step(16'h0007, 26'h0, 32'h1, 32'h1, 2'b01, 2'b00, 1'b0);       // R10 hold

    for (int i = 0; i < 3000; i++) begin
      a = $urandom;
      b = ($urandom % 2) ? a : $urandom;
      step(16'($urandom), 26'($urandom), a, b, 2'($urandom), 2'($urandom),
           1'(($urandom % 8) != 0));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule